// File: doc/BRIEF.md
# Prioritized Interrupt Level Controller

This block keeps pending interrupt requests arranged by priority level, with many independent source bits in each level. For every level it also holds a one-bit summary flag that is set while any source of that level is pending. Requests come in through separate post and clear command ports, and a clear-all strobe wipes everything at once.

Each cycle the block merges a software request vector with the pending external levels to find the highest active priority. Software bits map to low priorities through an offset, and any pending external level takes precedence over them. When that priority is nonzero, strictly above the current mask and the program counter is word aligned, an interrupt request is raised. The winning priority and the summary vector are then held with a valid flag. They reach the status outputs only when a separate acknowledge strobe arrives. An acknowledge with nothing held sets a sticky protocol error. A malformed command sets a sticky command error. An asynchronous-trap request, which is not supported, is flagged at once.

Top module: `irq_level_ctrl`

## Requirements
- R1: A post with level L < 32 and source S < 64 sets pending bit S of level L on the next clock edge, which also marks level L as non-empty.
- R2: A clear resets one pending bit. The level stays marked non-empty while any other source bit of that level remains set.
- R3: A clear-all strobe empties every level on the next clock edge and takes precedence over a post or clear in the same cycle.
- R4: A post or clear with a level of 32 or more, or a source of 64 or more, changes no pending state and sets the sticky `cmd_err` flag.
- R5: When a post and a clear name the same level and source in the same cycle, the bit ends up cleared. When they name different bits, both take effect.
- R6: `int_possible` is 1 exactly when at least one level is non-empty and `pc_lo` equals 2'b00.
- R7: A software request bit i with 1 <= i <= 15 gives priority i-1+1 and sets bit i of the computed summary. The highest such bit decides the priority. Software bits 0 and 16..31 are ignored.
- R8: A non-empty level i with 16 <= i <= 31 gives priority i and sets summary bit i. The highest such level decides the priority and overrides any software-derived priority. Non-empty levels 0..15 do not enter the summary.
- R9: `irq_req` is 1 exactly when `pc_lo` is 2'b00, the computed priority is nonzero, and it is strictly greater than `ipl_mask`.
- R10: In every cycle with `irq_req` high and no `ack`, the priority and summary are captured and `info_pending` is set. `int_id` and `isr_sum` change only on an `ack` while `info_pending` is 1. That `ack` loads the captured values and clears `info_pending`.
- R11: An `ack` while `info_pending` is 0 leaves `int_id` and `isr_sum` unchanged and sets the sticky `proto_err` flag.
- R12: `trap_err` is 1 whenever `trap_req` is 1.
- R13: A synchronous active-high reset empties all levels and zeroes `int_id`, `isr_sum`, `info_pending`, `cmd_err` and `proto_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| post_vld | input | 1 | Post command strobe |
| post_lvl | input | 6 | Post target level |
| post_src | input | 7 | Post target source bit |
| clr_vld | input | 1 | Clear command strobe |
| clr_lvl | input | 6 | Clear target level |
| clr_src | input | 7 | Clear target source bit |
| clr_all | input | 1 | Empty every level |
| sw_req | input | 32 | Software request vector |
| ipl_mask | input | 5 | Current priority mask |
| pc_lo | input | 2 | Low two bits of the program counter |
| trap_req | input | 1 | Asynchronous-trap request (unsupported) |
| ack | input | 1 | Acknowledge: commit captured priority and summary |
| int_possible | output | 1 | Some level non-empty and PC aligned |
| irq_req | output | 1 | Interrupt request |
| info_pending | output | 1 | Captured priority and summary awaiting acknowledge |
| isr_sum | output | 32 | Committed summary vector |
| int_id | output | 5 | Committed priority |
| cmd_err | output | 1 | Sticky out-of-range command flag |
| proto_err | output | 1 | Sticky acknowledge-without-capture flag |
| trap_err | output | 1 | Asynchronous-trap error indication |

## Verification
The assertions take for granted that reset is held for at least one edge before any command, and that a post whose effect is checked is not paired with any clear or clear-all in the same cycle. The stimulus never overlaps those cases except in dedicated directed steps, where the result is checked at the ports instead. All inputs change on the falling edge, so each command is a clean one-cycle pulse. The acknowledge is only pulsed after a capture edge, except in the step that deliberately provokes the protocol error.

// File: rtl/irq_level_pkg.sv
package irq_level_pkg;

    localparam int unsigned DEF_LEVELS  = 32;
    localparam int unsigned DEF_SOURCES = 64;
    localparam int unsigned DEF_SW_LO   = 1;
    localparam int unsigned DEF_SW_HI   = 16;
    localparam int unsigned DEF_EXT_LO  = 16;
    localparam int unsigned DEF_EXT_HI  = 32;

endpackage

// File: rtl/irq_pend_store.sv
module irq_pend_store #(
    parameter int unsigned NL = 32,
    parameter int unsigned NS = 64,
    localparam int unsigned LW = $clog2(NL),
    localparam int unsigned SW = $clog2(NS),
    localparam int unsigned LI = LW + 1,
    localparam int unsigned SI = SW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          post_vld,
    input  logic [LI-1:0] post_lvl,
    input  logic [SI-1:0] post_src,
    input  logic          clr_vld,
    input  logic [LI-1:0] clr_lvl,
    input  logic [SI-1:0] clr_src,
    input  logic          clr_all,
    output logic [NL-1:0] pend_sum,
    output logic          cmd_err
);

    localparam logic [LI-1:0] NL_L = LI'(NL);
    localparam logic [SI-1:0] NS_L = SI'(NS);

    typedef struct packed {
        logic [NL-1:0][NS-1:0] pend;
        logic [NL-1:0]         sum;
        logic                  err;
    } store_t;

    store_t st_d, st_q;
    logic   post_ok, clr_ok;

    always_comb begin
        st_d    = st_q;
        post_ok = post_vld && (post_lvl < NL_L) && (post_src < NS_L);
        clr_ok  = clr_vld  && (clr_lvl  < NL_L) && (clr_src  < NS_L);
        if (post_ok) begin
            st_d.pend[post_lvl[LW-1:0]][post_src[SW-1:0]] = 1'b1;
        end
        // clear applied after post, so it wins on the same bit
        if (clr_ok) begin
            st_d.pend[clr_lvl[LW-1:0]][clr_src[SW-1:0]] = 1'b0;
        end
        if (clr_all) begin
            st_d.pend = '0;
        end
        for (int l = 0; l < NL; l++) begin
            st_d.sum[l] = |st_d.pend[l];
        end
        st_d.err = st_q.err | (post_vld & ~post_ok) | (clr_vld & ~clr_ok);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_sum = st_q.sum;
    assign cmd_err  = st_q.err;

endmodule

// File: rtl/irq_prio_eval.sv
module irq_prio_eval #(
    parameter int unsigned NL     = 32,
    parameter int unsigned SW_LO  = 1,
    parameter int unsigned SW_HI  = 16,
    parameter int unsigned EXT_LO = 16,
    parameter int unsigned EXT_HI = 32,
    localparam int unsigned LW = $clog2(NL)
) (
    input  logic [NL-1:0] sw_req,
    input  logic [NL-1:0] pend_sum,
    output logic [LW-1:0] prio,
    output logic [NL-1:0] summ
);

    always_comb begin
        prio = '0;
        summ = '0;
        // software scan first, upward: highest bit wins
        for (int i = SW_LO; i < SW_HI; i++) begin
            if (sw_req[i]) begin
                prio    = LW'(i - SW_LO + 1);
                summ[i] = 1'b1;
            end
        end
        // external scan afterwards, overriding any software priority
        for (int i = EXT_LO; i < EXT_HI; i++) begin
            if (pend_sum[i]) begin
                prio    = LW'(i);
                summ[i] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl
    import irq_level_pkg::*;
#(
    parameter int unsigned NL     = DEF_LEVELS,
    parameter int unsigned NS     = DEF_SOURCES,
    parameter int unsigned SW_LO  = DEF_SW_LO,
    parameter int unsigned SW_HI  = DEF_SW_HI,
    parameter int unsigned EXT_LO = DEF_EXT_LO,
    parameter int unsigned EXT_HI = DEF_EXT_HI,
    localparam int unsigned LW = $clog2(NL),
    localparam int unsigned LI = LW + 1,
    localparam int unsigned SI = $clog2(NS) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          post_vld,
    input  logic [LI-1:0] post_lvl,
    input  logic [SI-1:0] post_src,
    input  logic          clr_vld,
    input  logic [LI-1:0] clr_lvl,
    input  logic [SI-1:0] clr_src,
    input  logic          clr_all,
    input  logic [NL-1:0] sw_req,
    input  logic [LW-1:0] ipl_mask,
    input  logic [1:0]    pc_lo,
    input  logic          trap_req,
    input  logic          ack,
    output logic          int_possible,
    output logic          irq_req,
    output logic          info_pending,
    output logic [NL-1:0] isr_sum,
    output logic [LW-1:0] int_id,
    output logic          cmd_err,
    output logic          proto_err,
    output logic          trap_err
);

    typedef struct packed {
        logic [LW-1:0] cap_prio;
        logic [NL-1:0] cap_summ;
        logic          cap_vld;
        logic [NL-1:0] isr;
        logic [LW-1:0] id;
        logic          perr;
    } ctl_t;

    ctl_t          ctl_d, ctl_q;
    logic [NL-1:0] pend_sum;
    logic [LW-1:0] cur_prio;
    logic [NL-1:0] cur_summ;
    logic          pc_aligned;
    logic          irq_w;

    irq_pend_store #(.NL(NL), .NS(NS)) u_store (
        .clk      (clk),
        .rst      (rst),
        .post_vld (post_vld),
        .post_lvl (post_lvl),
        .post_src (post_src),
        .clr_vld  (clr_vld),
        .clr_lvl  (clr_lvl),
        .clr_src  (clr_src),
        .clr_all  (clr_all),
        .pend_sum (pend_sum),
        .cmd_err  (cmd_err)
    );

    irq_prio_eval #(
        .NL(NL), .SW_LO(SW_LO), .SW_HI(SW_HI), .EXT_LO(EXT_LO), .EXT_HI(EXT_HI)
    ) u_eval (
        .sw_req   (sw_req),
        .pend_sum (pend_sum),
        .prio     (cur_prio),
        .summ     (cur_summ)
    );

    assign pc_aligned = (pc_lo == 2'b00);
    assign irq_w      = pc_aligned && (cur_prio != '0) && (cur_prio > ipl_mask);

    always_comb begin
        ctl_d = ctl_q;
        if (ack) begin
            if (ctl_q.cap_vld) begin
                ctl_d.isr     = ctl_q.cap_summ;
                ctl_d.id      = ctl_q.cap_prio;
                ctl_d.cap_vld = 1'b0;
            end else begin
                ctl_d.perr = 1'b1;
            end
        end else if (irq_w) begin
            ctl_d.cap_prio = cur_prio;
            ctl_d.cap_summ = cur_summ;
            ctl_d.cap_vld  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign int_possible = (pend_sum != '0) && pc_aligned;
    assign irq_req      = irq_w;
    assign info_pending = ctl_q.cap_vld;
    assign isr_sum      = ctl_q.isr;
    assign int_id       = ctl_q.id;
    assign proto_err    = ctl_q.perr;
    assign trap_err     = trap_req;

endmodule

// File: rtl/irq_level_ctrl_chk.sv
module irq_level_ctrl_chk #(
    parameter int unsigned NL = 32,
    parameter int unsigned NS = 64,
    localparam int unsigned LW = $clog2(NL),
    localparam int unsigned LI = LW + 1,
    localparam int unsigned SI = $clog2(NS) + 1
) (
    input logic          clk,
    input logic          rst,
    input logic          post_vld,
    input logic [LI-1:0] post_lvl,
    input logic [SI-1:0] post_src,
    input logic          clr_vld,
    input logic          clr_all,
    input logic [LW-1:0] ipl_mask,
    input logic [1:0]    pc_lo,
    input logic          ack,
    input logic [NL-1:0] pend_sum,
    input logic [LW-1:0] cur_prio,
    input logic          int_possible,
    input logic          irq_req,
    input logic          info_pending,
    input logic [NL-1:0] isr_sum,
    input logic [LW-1:0] int_id,
    input logic          cmd_err,
    input logic          proto_err
);

    localparam logic [LI-1:0] NL_L = LI'(NL);
    localparam logic [SI-1:0] NS_L = SI'(NS);

    logic lone_good_post;
    assign lone_good_post = post_vld && (post_lvl < NL_L) && (post_src < NS_L)
                            && !clr_vld && !clr_all;

    a_r1_post_marks_level: assert property (@(posedge clk) disable iff (rst)
        lone_good_post |=> pend_sum[$past(post_lvl[LW-1:0])]);

    a_r3_clear_all_empties: assert property (@(posedge clk) disable iff (rst)
        clr_all |=> (pend_sum == '0));

    a_r4_bad_level_flags: assert property (@(posedge clk) disable iff (rst)
        (post_vld && (post_lvl >= NL_L) && !clr_vld && !clr_all)
        |=> (cmd_err && $stable(pend_sum)));

    a_r6_possible_needs_align: assert property (@(posedge clk) disable iff (rst)
        int_possible |-> (pc_lo == 2'b00));

    a_r9_irq_above_mask: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (cur_prio > ipl_mask));

    a_r10_ack_consumes: assert property (@(posedge clk) disable iff (rst)
        (ack && info_pending) |=> !info_pending);

    a_r10_status_holds: assert property (@(posedge clk) disable iff (rst)
        !ack |=> ($stable(int_id) && $stable(isr_sum)));

    a_r11_bad_ack_flags: assert property (@(posedge clk) disable iff (rst)
        (ack && !info_pending) |=> (proto_err && $stable(int_id)));

    a_r11_proto_sticky: assert property (@(posedge clk) disable iff (rst)
        proto_err |=> proto_err);

endmodule

bind irq_level_ctrl irq_level_ctrl_chk #(.NL(NL), .NS(NS)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .post_vld     (post_vld),
    .post_lvl     (post_lvl),
    .post_src     (post_src),
    .clr_vld      (clr_vld),
    .clr_all      (clr_all),
    .ipl_mask     (ipl_mask),
    .pc_lo        (pc_lo),
    .ack          (ack),
    .pend_sum     (pend_sum),
    .cur_prio     (cur_prio),
    .int_possible (int_possible),
    .irq_req      (irq_req),
    .info_pending (info_pending),
    .isr_sum      (isr_sum),
    .int_id       (int_id),
    .cmd_err      (cmd_err),
    .proto_err    (proto_err)
);

// File: tb/irq_level_ctrl_tb.sv
`timescale 1ns/1ps
module irq_level_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        post_vld, clr_vld, clr_all, trap_req, ack;
    logic [5:0]  post_lvl, clr_lvl;
    logic [6:0]  post_src, clr_src;
    logic [31:0] sw_req;
    logic [4:0]  ipl_mask;
    logic [1:0]  pc_lo;
    logic        int_possible, irq_req, info_pending, cmd_err, proto_err, trap_err;
    logic [31:0] isr_sum;
    logic [4:0]  int_id;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    irq_level_ctrl u_dut (
        .clk(clk), .rst(rst),
        .post_vld(post_vld), .post_lvl(post_lvl), .post_src(post_src),
        .clr_vld(clr_vld), .clr_lvl(clr_lvl), .clr_src(clr_src),
        .clr_all(clr_all), .sw_req(sw_req), .ipl_mask(ipl_mask),
        .pc_lo(pc_lo), .trap_req(trap_req), .ack(ack),
        .int_possible(int_possible), .irq_req(irq_req),
        .info_pending(info_pending), .isr_sum(isr_sum), .int_id(int_id),
        .cmd_err(cmd_err), .proto_err(proto_err), .trap_err(trap_err)
    );

    // cmd: 0 none, 1 post, 2 clear, 3 clear-all
    typedef struct packed {
        logic [1:0]  cmd;
        logic [5:0]  lvl;
        logic [6:0]  src;
        logic [31:0] sw;
        logic [4:0]  mask;
        logic        x_poss;
        logic        x_irq;
        logic [4:0]  x_id;
        logic [31:0] x_sum;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t TBL [NV] = '{
        '{2'd1, 6'd20, 7'd5,  32'h0,         5'd0,  1'b1, 1'b1, 5'd20, 32'h0010_0000},
        '{2'd1, 6'd25, 7'd63, 32'h0,         5'd0,  1'b1, 1'b1, 5'd25, 32'h0210_0000},
        '{2'd2, 6'd25, 7'd63, 32'h0,         5'd0,  1'b1, 1'b1, 5'd20, 32'h0010_0000},
        '{2'd0, 6'd0,  7'd0,  32'h0000_0008, 5'd0,  1'b1, 1'b1, 5'd20, 32'h0010_0008},
        '{2'd1, 6'd20, 7'd7,  32'h0,         5'd20, 1'b1, 1'b0, 5'd0,  32'h0},
        '{2'd2, 6'd20, 7'd5,  32'h0,         5'd19, 1'b1, 1'b1, 5'd20, 32'h0010_0000},
        '{2'd2, 6'd20, 7'd7,  32'h0,         5'd0,  1'b0, 1'b0, 5'd0,  32'h0},
        '{2'd0, 6'd0,  7'd0,  32'h0000_0204, 5'd4,  1'b0, 1'b1, 5'd9,  32'h0000_0204},
        '{2'd0, 6'd0,  7'd0,  32'h0000_0200, 5'd9,  1'b0, 1'b0, 5'd0,  32'h0},
        '{2'd1, 6'd40, 7'd1,  32'h0,         5'd0,  1'b0, 1'b0, 5'd0,  32'h0},
        '{2'd1, 6'd5,  7'd70, 32'h0,         5'd0,  1'b0, 1'b0, 5'd0,  32'h0},
        '{2'd1, 6'd5,  7'd0,  32'h0,         5'd0,  1'b1, 1'b0, 5'd0,  32'h0},
        '{2'd1, 6'd31, 7'd0,  32'h0,         5'd0,  1'b1, 1'b1, 5'd31, 32'h8000_0000},
        '{2'd3, 6'd0,  7'd0,  32'h0,         5'd0,  1'b0, 1'b0, 5'd0,  32'h0},
        '{2'd0, 6'd0,  7'd0,  32'h0010_0001, 5'd0,  1'b0, 1'b0, 5'd0,  32'h0}
    };

    task automatic check(input bit ok, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic idle_cmds();
        post_vld = 1'b0; clr_vld = 1'b0; clr_all = 1'b0;
        post_lvl = '0; post_src = '0; clr_lvl = '0; clr_src = '0;
    endtask

    task automatic next_neg();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_ack();
        ack = 1'b1;
        next_neg();
        ack = 1'b0;
        #1;
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; ack = 1'b0; trap_req = 1'b0;
        sw_req = '0; ipl_mask = '0; pc_lo = 2'b00;
        idle_cmds();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R13 reset state
        check(!int_possible && !irq_req, "R13 idle after reset", {int_possible, irq_req}, 0);
        check(int_id == 0 && isr_sum == 0, "R13 status zero", {int_id, isr_sum}, 0);
        check(!info_pending && !cmd_err && !proto_err, "R13 flags zero",
              {info_pending, cmd_err, proto_err}, 0);

        // table walk
        for (int k = 0; k < NV; k++) begin
            vec_t v;
            v = TBL[k];
            @(negedge clk);
            sw_req = v.sw; ipl_mask = v.mask; pc_lo = 2'b00;
            case (v.cmd)
                2'd1: begin post_vld = 1'b1; post_lvl = v.lvl; post_src = v.src; end
                2'd2: begin clr_vld = 1'b1; clr_lvl = v.lvl; clr_src = v.src; end
                2'd3: clr_all = 1'b1;
                default: ;
            endcase
            next_neg();
            idle_cmds();
            #1;
            check(int_possible == v.x_poss, $sformatf("R6 possible vec %0d", k),
                  int_possible, v.x_poss);
            check(irq_req == v.x_irq, $sformatf("R9 irq vec %0d", k), irq_req, v.x_irq);
            if (v.x_irq) begin
                next_neg();
                do_ack();
                check(int_id == v.x_id, $sformatf("R7/R8 R10 id vec %0d", k), int_id, v.x_id);
                check(isr_sum == v.x_sum, $sformatf("R7/R8 R10 summary vec %0d", k),
                      isr_sum, v.x_sum);
            end
        end
        sw_req = '0; ipl_mask = '0;

        // R4 sticky command error after out-of-range posts
        check(cmd_err == 1'b1, "R4 cmd_err sticky", cmd_err, 1);

        // R5 same-bit post and clear: clear wins
        @(negedge clk);
        post_vld = 1'b1; post_lvl = 6'd18; post_src = 7'd3;
        clr_vld  = 1'b1; clr_lvl  = 6'd18; clr_src  = 7'd3;
        next_neg();
        idle_cmds();
        #1;
        check(int_possible == 1'b0, "R5 clear wins same bit", int_possible, 0);
        // R5 different bits both take effect
        post_vld = 1'b1; post_lvl = 6'd18; post_src = 7'd3;
        clr_vld  = 1'b1; clr_lvl  = 6'd18; clr_src  = 7'd4;
        next_neg();
        idle_cmds();
        #1;
        check(int_possible == 1'b1, "R5 distinct bits both apply", int_possible, 1);
        // R2 clearing another source bit of level 18 keeps it marked
        clr_vld = 1'b1; clr_lvl = 6'd18; clr_src = 7'd9;
        next_neg();
        idle_cmds();
        #1;
        check(int_possible == 1'b1, "R2 level kept while sources remain", int_possible, 1);
        // R3 clear-all beats a simultaneous post
        clr_all = 1'b1; post_vld = 1'b1; post_lvl = 6'd21; post_src = 7'd0;
        next_neg();
        idle_cmds();
        #1;
        check(int_possible == 1'b0 && irq_req == 1'b0, "R3 clear-all precedence",
              {int_possible, irq_req}, 0);

        // R6 / R9 alignment gating
        post_vld = 1'b1; post_lvl = 6'd17; post_src = 7'd0;
        pc_lo = 2'b01;
        next_neg();
        idle_cmds();
        #1;
        check(int_possible == 1'b0 && irq_req == 1'b0, "R6 R9 misaligned pc blocks",
              {int_possible, irq_req}, 0);
        pc_lo = 2'b10;
        #1;
        check(irq_req == 1'b0, "R9 pc bit1 blocks", irq_req, 0);
        pc_lo = 2'b00;
        #1;
        check(int_possible == 1'b1 && irq_req == 1'b1, "R6 R9 aligned pc allows",
              {int_possible, irq_req}, 2'b11);

        // R10 capture without acknowledge leaves status untouched
        next_neg();
        next_neg();
        #1;
        check(info_pending == 1'b1, "R10 capture held", info_pending, 1);
        check(int_id == 5'd31, "R10 id waits for ack", int_id, 31);
        // acknowledge and remove level 17 in the same cycle
        ack = 1'b1;
        clr_vld = 1'b1; clr_lvl = 6'd17; clr_src = 7'd0;
        next_neg();
        ack = 1'b0;
        idle_cmds();
        #1;
        check(int_id == 5'd17 && !info_pending, "R10 ack commits",
              {info_pending, int_id}, 17);
        check(isr_sum == 32'h0002_0000, "R10 summary commit", isr_sum, 32'h0002_0000);

        // R11 acknowledge with nothing captured
        check(proto_err == 1'b0, "R11 no error before", proto_err, 0);
        do_ack();
        check(proto_err == 1'b1, "R11 proto_err set", proto_err, 1);
        check(int_id == 5'd17 && isr_sum == 32'h0002_0000, "R11 status unchanged",
              {int_id, isr_sum}, {5'd17, 32'h0002_0000});
        next_neg();
        #1;
        check(proto_err == 1'b1, "R11 proto_err sticky", proto_err, 1);

        // R12 trap request flagged
        trap_req = 1'b1;
        #1;
        check(trap_err == 1'b1, "R12 trap error", trap_err, 1);
        trap_req = 1'b0;
        #1;
        check(trap_err == 1'b0, "R12 trap error drops", trap_err, 0);

        // R13 reset clears sticky flags and status
        rst = 1'b1;
        next_neg();
        rst = 1'b0;
        #1;
        check(!proto_err && !cmd_err && int_id == 0 && isr_sum == 0, "R13 reset clears",
              {proto_err, cmd_err, int_id, isr_sum}, 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule